// File: doc/BRIEF.md
# Two-Channel Volume Mixer With Shared Rate Group

This block merges the decoded sample streams of two playback channels into a single 14-bit output word. Each channel has its own 5-bit volume code and its own active flag, so the channels start and stop independently. Each incoming 16-bit signed sample is multiplied by an unsigned 16-bit fractional gain derived from the channel's volume code. The two scaled values are added together, and the sum is clamped to the signed 14-bit range. On every output sample tick the block emits one mixed word together with a one-cycle strobe.

Each channel also holds one piece of rate state. Sample rates belong to four families, and the members of a family are binary multiples of a base rate. When a channel becomes active while no channel is active, its requested family becomes the shared family for the output. A channel that starts beside an already playing channel keeps its own multiplier but takes on the shared family. For example, a 25.6 kHz request placed beside a 16.0 kHz channel plays as 32.0 kHz. The shared family is released only once both channels are idle.

The sample inputs use a valid/ready stream. Ready equals the channel's active flag. A sample offered while ready is low is dropped and is not stored. While the channel is active, each accepted sample replaces the channel's held value, and the mix uses the held value. The output has no back-pressure: downstream logic must take each word in the cycle its strobe is high.

Top module: `mix2_core`

## Requirements
- R1: Every cycle with `tick_i` high is followed, one cycle later, by exactly one cycle with `out_valid_o` high. `out_word_o` then holds the saturated sum of both scaled channels, computed from the held samples, volumes and active flags present in the tick cycle. `out_word_o` changes only together with a strobe.
- R2: A channel's scaled value is floor(sample × gain / 65536), where gain = code × 2340 for volume codes 1 to 28 (code 28 gives 65520).
- R3: A sum above +8191 is output as +8191, and a sum below −8192 is output as −8192. The result never wraps.
- R4: Volume code 0 makes a channel contribute zero.
- R5: Volume codes 29, 30 and 31 give the same result as code 28.
- R6: An inactive channel contributes zero. This includes a tick that falls in the same cycle its active flag drops.
- R7: After reset, `out_valid_o` is low, `out_word_o` is 0, both rate outputs are 0 and `out_grp_o` is 0. `out_valid_o` stays low in every cycle that does not follow a tick.
- R8: A channel whose active flag rises while no channel was active in the previous cycle sets `out_grp_o` to its requested family, one cycle later. If both channels rise in the same cycle, channel 0's family wins.
- R9: A channel that rises while the other channel is active reports a rate of {shared family, own multiplier}. The rate output is 4 bits wide, with the family in bits 3:2 and the multiplier in bits 1:0. The shared family does not change while any channel stays active.
- R10: Once both channels have been idle, the next channel to start reports its own requested family and multiplier.
- R11: `sN_ready_o` equals channel N's active flag. A sample offered while the channel is inactive is not stored, and an inactive channel's held sample is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Output sample tick |
| s0_valid_i | input | 1 | Channel 0 sample valid |
| s0_ready_o | output | 1 | Channel 0 sample ready (equals act0_i) |
| s0_data_i | input | 16 | Channel 0 signed sample |
| s1_valid_i | input | 1 | Channel 1 sample valid |
| s1_ready_o | output | 1 | Channel 1 sample ready (equals act1_i) |
| s1_data_i | input | 16 | Channel 1 signed sample |
| vol0_i | input | 5 | Channel 0 volume code |
| vol1_i | input | 5 | Channel 1 volume code |
| act0_i | input | 1 | Channel 0 active |
| act1_i | input | 1 | Channel 1 active |
| grp0_i | input | 2 | Channel 0 requested rate family |
| mult0_i | input | 2 | Channel 0 requested multiplier |
| grp1_i | input | 2 | Channel 1 requested rate family |
| mult1_i | input | 2 | Channel 1 requested multiplier |
| out_valid_o | output | 1 | Mixed word strobe |
| out_word_o | output | 14 | Mixed, saturated signed word |
| out_grp_o | output | 2 | Shared rate family |
| rate0_o | output | 4 | Channel 0 effective rate {family, multiplier} |
| rate1_o | output | 4 | Channel 1 effective rate {family, multiplier} |

## Verification
The assertions check the following on every cycle:
- the one-cycle strobe after each tick, and the absence of any strobe without a tick;
- that the output word holds between strobes;
- the zero result when both channels are muted or both are idle;
- that the shared family holds steady while a channel stays active.

The bench scenarios cover what those properties cannot show:
- the exact arithmetic of the gain law;
- clamping at both limits;
- the equivalence of the codes above 28;
- the same-cycle drop of a channel;
- the dropping of samples offered while a channel is idle;
- the sequence of family lock, forced family and release.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int NCH           = 2;
  localparam int VOL_MAX_DEF   = 28;
  localparam int GAIN_STEP_DEF = 2340;
endpackage

// File: rtl/mix_scale.sv
module mix_scale #(
  parameter int SAMPLE_W  = 16,
  parameter int VOL_W     = 5,
  parameter int GAIN_W    = 16,
  parameter int VOL_MAX   = 28,
  parameter int GAIN_STEP = 2340
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [VOL_W-1:0]    vol_i,
  input  logic                       act_i,
  output logic signed [SAMPLE_W:0]   scaled_o
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

  logic [VOL_W-1:0]         code_eff;
  logic [GAIN_W-1:0]        gain;
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    code_eff = (vol_i > VOL_W'(VOL_MAX)) ? VOL_W'(VOL_MAX) : vol_i;
    gain     = GAIN_W'(int'(code_eff) * GAIN_STEP);
    prod     = sample_i * $signed({1'b0, gain});
    // the top slice of the product is the floor of the division by 2**GAIN_W
    scaled_o = act_i ? $signed(prod[PROD_W-1:GAIN_W]) : '0;
  end
endmodule

// File: rtl/mix_sat.sv
module mix_sat #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 14
) (
  input  logic signed [IN_W-1:0]  in_i,
  output logic        [OUT_W-1:0] out_o
);
  localparam logic signed [IN_W-1:0] HI = IN_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [IN_W-1:0] LO = IN_W'(-(1 << (OUT_W - 1)));

  always_comb begin
    if (in_i > HI)      out_o = HI[OUT_W-1:0];
    else if (in_i < LO) out_o = LO[OUT_W-1:0];
    else                out_o = in_i[OUT_W-1:0];
  end
endmodule

// File: rtl/mix_rate_lock.sv
module mix_rate_lock #(
  parameter int NCH    = 2,
  parameter int GRP_W  = 2,
  parameter int MULT_W = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NCH-1:0]                   act_i,
  input  logic [NCH-1:0][GRP_W-1:0]        grp_req_i,
  input  logic [NCH-1:0][MULT_W-1:0]       mult_req_i,
  output logic [GRP_W-1:0]                 grp_o,
  output logic [NCH-1:0][GRP_W+MULT_W-1:0] rate_o
);
  logic [NCH-1:0]             act_q;
  logic [NCH-1:0]             rise;
  logic [GRP_W-1:0]           grp_q, grp_d;
  logic [NCH-1:0][MULT_W-1:0] mult_q;

  assign rise = act_i & ~act_q;

  // the family is free only when no channel was active; the lowest rising index wins
  always_comb begin
    grp_d = grp_q;
    if (act_q == '0) begin
      for (int c = NCH - 1; c >= 0; c--) begin
        if (rise[c]) grp_d = grp_req_i[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      grp_q <= '0;
    end else begin
      act_q <= act_i;
      grp_q <= grp_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mult_q[c] <= '0;
      else if (rise[c]) mult_q[c] <= mult_req_i[c];
    end
    assign rate_o[c] = {grp_q, mult_q[c]};
  end

  assign grp_o = grp_q;
endmodule

// File: rtl/mix2_core.sv
module mix2_core
  import mix_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int OUT_W     = 14,
  parameter int VOL_W     = 5,
  parameter int GAIN_W    = 16,
  parameter int VOL_MAX   = VOL_MAX_DEF,
  parameter int GAIN_STEP = GAIN_STEP_DEF,
  parameter int GRP_W     = 2,
  parameter int MULT_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic                      s0_valid_i,
  output logic                      s0_ready_o,
  input  logic [SAMPLE_W-1:0]       s0_data_i,
  input  logic                      s1_valid_i,
  output logic                      s1_ready_o,
  input  logic [SAMPLE_W-1:0]       s1_data_i,
  input  logic [VOL_W-1:0]          vol0_i,
  input  logic [VOL_W-1:0]          vol1_i,
  input  logic                      act0_i,
  input  logic                      act1_i,
  input  logic [GRP_W-1:0]          grp0_i,
  input  logic [MULT_W-1:0]         mult0_i,
  input  logic [GRP_W-1:0]          grp1_i,
  input  logic [MULT_W-1:0]         mult1_i,
  output logic                      out_valid_o,
  output logic [OUT_W-1:0]          out_word_o,
  output logic [GRP_W-1:0]          out_grp_o,
  output logic [GRP_W+MULT_W-1:0]   rate0_o,
  output logic [GRP_W+MULT_W-1:0]   rate1_o
);
  localparam int SCL_W  = SAMPLE_W + 1;
  localparam int SUM_W  = SCL_W + 1;
  localparam int RATE_W = GRP_W + MULT_W;

  logic [NCH-1:0]                act;
  logic [NCH-1:0]                vld;
  logic [NCH-1:0][SAMPLE_W-1:0]  din;
  logic [NCH-1:0][VOL_W-1:0]     vol;
  logic [NCH-1:0][SAMPLE_W-1:0]  held;
  logic [NCH-1:0][SCL_W-1:0]     scaled;
  logic signed [SUM_W-1:0]       sum;
  logic [OUT_W-1:0]              sat_word;
  logic [NCH-1:0][RATE_W-1:0]    rates;

  assign act = {act1_i, act0_i};
  assign vld = {s1_valid_i, s0_valid_i};
  assign din = {s1_data_i, s0_data_i};
  assign vol = {vol1_i, vol0_i};

  assign s0_ready_o = act[0];
  assign s1_ready_o = act[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                held[c] <= '0;
      else if (!act[c])          held[c] <= '0;
      else if (vld[c])           held[c] <= din[c];
    end

    mix_scale #(
      .SAMPLE_W (SAMPLE_W),
      .VOL_W    (VOL_W),
      .GAIN_W   (GAIN_W),
      .VOL_MAX  (VOL_MAX),
      .GAIN_STEP(GAIN_STEP)
    ) u_scale (
      .sample_i ($signed(held[c])),
      .vol_i    (vol[c]),
      .act_i    (act[c]),
      .scaled_o (scaled[c])
    );
  end

  assign sum = $signed({scaled[0][SCL_W-1], scaled[0]})
             + $signed({scaled[1][SCL_W-1], scaled[1]});

  mix_sat #(.IN_W(SUM_W), .OUT_W(OUT_W)) u_sat (
    .in_i (sum),
    .out_o(sat_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_word_o  <= '0;
    end else begin
      out_valid_o <= tick_i;
      if (tick_i) out_word_o <= sat_word;
    end
  end

  mix_rate_lock #(.NCH(NCH), .GRP_W(GRP_W), .MULT_W(MULT_W)) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_i     (act),
    .grp_req_i ({grp1_i, grp0_i}),
    .mult_req_i({mult1_i, mult0_i}),
    .grp_o     (out_grp_o),
    .rate_o    (rates)
  );

  assign rate0_o = rates[0];
  assign rate1_o = rates[1];
endmodule

// File: rtl/mix2_checker.sv
module mix2_checker #(
  parameter int OUT_W = 14,
  parameter int VOL_W = 5,
  parameter int GRP_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             act0_i,
  input logic             act1_i,
  input logic [VOL_W-1:0] vol0_i,
  input logic [VOL_W-1:0] vol1_i,
  input logic             out_valid_o,
  input logic [OUT_W-1:0] out_word_o,
  input logic [GRP_W-1:0] out_grp_o
);
  assert_strobe_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> out_valid_o);

  assert_no_stray_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !out_valid_o);

  assert_word_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> $stable(out_word_o));

  assert_mute_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && vol0_i == '0 && vol1_i == '0) |=> out_word_o == '0);

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !act0_i && !act1_i) |=> out_word_o == '0);

  assert_family_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act0_i || act1_i) ##1 (act0_i || act1_i) |=> $stable(out_grp_o));
endmodule

bind mix2_core mix2_checker #(.OUT_W(OUT_W), .VOL_W(VOL_W), .GRP_W(GRP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .act0_i     (act0_i),
  .act1_i     (act1_i),
  .vol0_i     (vol0_i),
  .vol1_i     (vol1_i),
  .out_valid_o(out_valid_o),
  .out_word_o (out_word_o),
  .out_grp_o  (out_grp_o)
);

// File: tb/tb_mix2_core.sv
`timescale 1ns/1ps
module tb_mix2_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        s0_valid_i = 1'b0, s1_valid_i = 1'b0;
  logic        s0_ready_o, s1_ready_o;
  logic [15:0] s0_data_i = '0, s1_data_i = '0;
  logic [4:0]  vol0_i = '0, vol1_i = '0;
  logic        act0_i = 1'b0, act1_i = 1'b0;
  logic [1:0]  grp0_i = '0, mult0_i = '0, grp1_i = '0, mult1_i = '0;
  logic        out_valid_o;
  logic [13:0] out_word_o;
  logic [1:0]  out_grp_o;
  logic [3:0]  rate0_o, rate1_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  mix2_core dut (.*);

  function automatic int exp_scale(int s, int code, bit act);
    longint p;
    int c;
    if (!act) return 0;
    c = (code > 28) ? 28 : code;
    if (c == 0) return 0;
    p = longint'(s) * c * 2340;
    return int'(p >>> 16);
  endfunction

  function automatic int exp_sat(int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  task automatic chk(string req, int actual, int expected);
    n_tests++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic load(int ch, int s);
    @(negedge clk);
    if (ch == 0) begin s0_valid_i = 1'b1; s0_data_i = 16'(s); end
    else         begin s1_valid_i = 1'b1; s1_data_i = 16'(s); end
    @(negedge clk);
    s0_valid_i = 1'b0;
    s1_valid_i = 1'b0;
  endtask

  task automatic tick_check(string req, int expected);
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk({req, " strobe"}, int'(out_valid_o), 1);
    chk(req, int'($signed(out_word_o)), expected);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int samp[6] = '{32767, -32768, 12345, -1, 1000, -7777};
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 valid", int'(out_valid_o), 0);
    chk("R7 word", int'(out_word_o), 0);
    chk("R7 grp", int'(out_grp_o), 0);
    chk("R7 rate0", int'(rate0_o), 0);
    chk("R7 rate1", int'(rate1_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready idle", int'(s0_ready_o), 0);

    // R2 R4 R5 R3: full volume sweep on channel 0 alone
    act0_i = 1'b1;
    for (int v = 0; v < 32; v++) begin
      for (int k = 0; k < 6; k++) begin
        load(0, samp[k]);
        vol0_i = 5'(v);
        tick_check("R2 ch0 sweep", exp_sat(exp_scale(samp[k], v, 1)));
      end
    end
    @(negedge clk);
    chk("R7 no strobe without tick", int'(out_valid_o), 0);

    // R5: codes 29..31 equal code 28
    for (int v = 29; v < 32; v++) begin
      load(0, 3000);
      vol0_i = 5'(v);
      tick_check("R5 clamp code", exp_scale(3000, 28, 1));
    end
    act0_i = 1'b0;

    // channel 1 sweep alone
    act1_i = 1'b1;
    for (int v = 0; v < 32; v++) begin
      for (int k = 2; k < 6; k++) begin
        load(1, samp[k]);
        vol1_i = 5'(v);
        tick_check("R2 ch1 sweep", exp_sat(exp_scale(samp[k], v, 1)));
      end
    end

    // R1 R3: pairs including saturation at both limits
    act0_i = 1'b1;
    for (int pv = 0; pv < 3; pv++) begin
      int va = (pv == 0) ? 28 : (pv == 1) ? 14 : 31;
      int vb = (pv == 0) ? 28 : (pv == 1) ? 20 : 7;
      for (int a = 0; a < 6; a++) begin
        for (int b = 0; b < 6; b++) begin
          load(0, samp[a]);
          load(1, samp[b]);
          vol0_i = 5'(va);
          vol1_i = 5'(vb);
          tick_check("R3 R1 pair", exp_sat(exp_scale(samp[a], va, 1) + exp_scale(samp[b], vb, 1)));
        end
      end
    end
    load(0, 32767); load(1, 32767); vol0_i = 28; vol1_i = 28;
    tick_check("R3 upper limit", 8191);
    load(0, -32768); load(1, -32768);
    tick_check("R3 lower limit", -8192);

    // R4: both muted
    vol0_i = 0; vol1_i = 0;
    tick_check("R4 both muted", 0);

    // R6: channel 1 drops in the tick cycle
    load(0, 4000); load(1, 3000); vol0_i = 28; vol1_i = 28;
    @(negedge clk);
    act1_i = 1'b0;
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk("R6 same-cycle drop", int'($signed(out_word_o)), exp_scale(4000, 28, 1));
    act0_i = 1'b0;
    tick_check("R6 both idle", 0);

    // R11: samples offered while idle are not stored
    @(negedge clk);
    chk("R11 ready low", int'(s1_ready_o), 0);
    load(1, 5000);
    act1_i = 1'b1;
    @(negedge clk);
    chk("R11 ready high", int'(s1_ready_o), 1);
    tick_check("R11 dropped sample", 0);
    act1_i = 1'b0;
    repeat (2) @(negedge clk);

    // R8: first start sets family; R9: second is forced
    grp0_i = 2'd0; mult0_i = 2'd2;
    act0_i = 1'b1;
    @(negedge clk);
    chk("R8 family lock", int'(out_grp_o), 0);
    chk("R8 rate0", int'(rate0_o), 4'b0010);
    grp1_i = 2'd3; mult1_i = 2'd2;
    act1_i = 1'b1;
    @(negedge clk);
    chk("R9 forced rate1", int'(rate1_o), 4'b0010);
    chk("R9 family kept", int'(out_grp_o), 0);
    act0_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 family held", int'(out_grp_o), 0);
    act1_i = 1'b0;
    repeat (2) @(negedge clk);

    // R10: start after both ended uses own family
    act1_i = 1'b1;
    @(negedge clk);
    chk("R10 own family", int'(out_grp_o), 3);
    chk("R10 own rate1", int'(rate1_o), 4'b1110);
    act1_i = 1'b0;
    repeat (2) @(negedge clk);

    // R8: simultaneous start, channel 0 wins
    grp0_i = 2'd1; mult0_i = 2'd1; grp1_i = 2'd2; mult1_i = 2'd3;
    act0_i = 1'b1; act1_i = 1'b1;
    @(negedge clk);
    chk("R8 tie family", int'(out_grp_o), 1);
    chk("R8 tie rate1", int'(rate1_o), 4'b0111);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule